// File: doc/BRIEF.md
# Ternary Stream Framing Detector

This block watches a received ternary line stream that has already been cut into three-symbol groups (triplets), one triplet per clock when the valid input is high. It finds the comma (six zero symbols in a row), checks the two triplets that must follow it, and reports what kind of control sequence went past. Ordinary data can never hold six zeros in a row, so a comma marks a control sequence without doubt.

A control sequence is always comma, then an end marker, then a start marker. The end marker says whether a plain control block ended (CTL_END) or a frame ended well (FRM_END_GOOD) or with an error (FRM_END_BAD). The start marker opens either another control block (CTL_START) or a frame (FRM_START). The start marker also resets the downstream disparity tracker and shows whether the wire pair is crossed. Every marker can arrive negated, and a negated start marker sets the polarity flag that later stages use to negate the symbols. The block follows whether the link is in a frame or in idle, reports broken sequences, and raises a sync-loss flag when idle goes on too long without a control sequence.

Top module: `tsf_framer`

## Requirements
- R1: A symbol is 2 bits: 2'b00 zero, 2'b01 plus, 2'b11 minus, 2'b10 illegal. A triplet is 6 bits with the first symbol in bits [5:4]. Two valid all-zero triplets in a row form a comma, and comma_o pulses in the cycle after the second one. A single zero triplet followed by any other triplet has no effect.
- R2: The marker codes, written as symbols in time order, are CTL_END = + 0 -, FRM_END_GOOD = 0 + -, FRM_END_BAD = + - 0, CTL_START = + + -, FRM_START = + + +. The sequence is complete when the triplet after a comma is an end marker and the next triplet is a start marker. In the cycle after the start-marker triplet, exactly one of eoc_o, eof_ok_o and eof_err_o pulses, matching the end marker, and exactly one of soc_o and sof_o pulses, matching the start marker.
- R3: Each marker is also recognised with every symbol negated (plus and minus swapped). The end marker and the start marker of one sequence must have the same polarity. On completion, pol_inv_o takes the polarity of the start marker (1 = negated) and holds it until the next completion.
- R4: disp_rst_o pulses together with the completion pulses of every complete sequence, and at no other time.
- R5: in_frame_o goes high after a sequence completes with FRM_START. It goes low after a sequence completes with CTL_START, and after any framing error.
- R6: Outside a frame only CTL_END is accepted as end marker. Inside a frame only FRM_END_GOOD or FRM_END_BAD is accepted. Any other end marker is a framing error.
- R7: An unrecognised end or start marker, or a polarity mismatch between them, pulses frame_err_o in the cycle after the offending triplet. That sequence produces no completion pulses, and the comma search restarts with the next triplet.
- R8: The block counts valid triplets received outside a frame since reset or since the last complete sequence. When that count reaches IDLE_LIMIT (default 256, that is 128 bytes of 4-bit triplets), sync_lost_o rises. Triplets received inside a frame are not counted.
- R9: sync_lost_o stays high until the next complete control sequence and clears in the cycle after it.
- R10: A cycle with trip_valid_i low changes no state and produces no pulse. A comma split by such cycles is still found.
- R11: During and right after reset, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trip_valid_i | input | 1 | A triplet is present this cycle |
| trip_i | input | 6 | Triplet, first symbol in [5:4] |
| comma_o | output | 1 | Comma found (pulse) |
| eoc_o | output | 1 | Sequence completed with CTL_END |
| eof_ok_o | output | 1 | Sequence completed with FRM_END_GOOD |
| eof_err_o | output | 1 | Sequence completed with FRM_END_BAD |
| soc_o | output | 1 | Sequence completed with CTL_START |
| sof_o | output | 1 | Sequence completed with FRM_START |
| disp_rst_o | output | 1 | Disparity reset pulse |
| pol_inv_o | output | 1 | Line polarity is negated |
| in_frame_o | output | 1 | Link is inside a frame |
| frame_err_o | output | 1 | Broken control sequence (pulse) |
| sync_lost_o | output | 1 | No control sequence for too long in idle |

## Verification
The bench goes after three kinds of corner case:
- **Split polarity.** An end marker in one polarity and a start marker in the other must give a framing error. A design that accepted it would flip pol_inv_o and pulse disp_rst_o.
- **Wrong end marker for the link state.** A frame-end marker in idle, or a control-end marker inside a frame, must be refused. A design that took it would leave in_frame_o wrong.
- **Zeros that are not a comma.** A lone zero triplet, and zeros separated by idle cycles, are also driven. A design that counted invalid cycles or forgot the first zero would miss commas or invent them.

The sync-loss counter is driven to exactly IDLE_LIMIT-1 and then IDLE_LIMIT idle triplets, to catch an off-by-one. A long frame is also sent, to show that triplets inside a frame do not count.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

    localparam int SYM_W     = 2;
    localparam int TRIP_SYMS = 3;
    localparam int TRIP_W    = SYM_W * TRIP_SYMS;
    localparam int N_CODES   = 5;

    localparam logic [SYM_W-1:0] S_ZERO  = 2'b00;
    localparam logic [SYM_W-1:0] S_PLUS  = 2'b01;
    localparam logic [SYM_W-1:0] S_MINUS = 2'b11;

    // marker kinds; code table index k maps to kind k+1
    typedef enum logic [2:0] {
        K_NONE    = 3'd0,
        K_EOC     = 3'd1,
        K_EOF_OK  = 3'd2,
        K_EOF_ERR = 3'd3,
        K_SOC     = 3'd4,
        K_SOF     = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        PH_STREAM = 2'd0,
        PH_ZERO1  = 2'd1,
        PH_ENDD   = 2'd2,
        PH_STARTD = 2'd3
    } phase_e;

    // normal-polarity marker codes, first symbol in the upper bits
    localparam logic [TRIP_W-1:0] CODE_TAB [N_CODES] = '{
        {S_PLUS,  S_ZERO,  S_MINUS},   // control end
        {S_ZERO,  S_PLUS,  S_MINUS},   // frame end, good
        {S_PLUS,  S_MINUS, S_ZERO },   // frame end, bad
        {S_PLUS,  S_PLUS,  S_MINUS},   // control start
        {S_PLUS,  S_PLUS,  S_PLUS }    // frame start
    };

    typedef struct packed {
        phase_e     phase;
        logic       in_frame;
        logic       pol;
        kind_e      ed_kind;
        logic       ed_inv;
        logic       comma;
        logic       eoc;
        logic       eof_ok;
        logic       eof_err;
        logic       soc;
        logic       sof;
        logic       drst;
        logic       ferr;
    } seq_t;

    function automatic logic [TRIP_W-1:0] negate_trip(input logic [TRIP_W-1:0] t);
        logic [TRIP_W-1:0] r;
        r = t;
        for (int i = 0; i < TRIP_SYMS; i++) begin
            if (t[SYM_W*i +: SYM_W] == S_PLUS)
                r[SYM_W*i +: SYM_W] = S_MINUS;
            else if (t[SYM_W*i +: SYM_W] == S_MINUS)
                r[SYM_W*i +: SYM_W] = S_PLUS;
        end
        return r;
    endfunction

endpackage

// File: rtl/tsf_classify.sv
module tsf_classify
    import tsf_pkg::*;
(
    input  logic [TRIP_W-1:0] trip_i,
    output kind_e             kind_o,
    output logic              inv_o,
    output logic              zero_o
);

    logic [N_CODES-1:0] hit_norm;
    logic [N_CODES-1:0] hit_inv;

    for (genvar g = 0; g < N_CODES; g++) begin : g_code
        assign hit_norm[g] = (trip_i == CODE_TAB[g]);
        assign hit_inv[g]  = (trip_i == negate_trip(CODE_TAB[g]));
    end

    assign zero_o = (trip_i == '0);

    always_comb begin
        kind_o = K_NONE;
        inv_o  = 1'b0;
        for (int k = 0; k < N_CODES; k++) begin
            if (hit_norm[k]) begin
                kind_o = kind_e'(3'(k + 1));
                inv_o  = 1'b0;
            end else if (hit_inv[k]) begin
                kind_o = kind_e'(3'(k + 1));
                inv_o  = 1'b1;
            end
        end
    end

    // R2
    always_comb begin
        code_unique_chk: assert ($onehot0({hit_norm, hit_inv}))
            else $error("triplet matches more than one marker code");
    end

endmodule

// File: rtl/tsf_seq.sv
module tsf_seq
    import tsf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  valid_i,
    input  kind_e kind_i,
    input  logic  inv_i,
    input  logic  zero_i,
    output logic  comma_o,
    output logic  eoc_o,
    output logic  eof_ok_o,
    output logic  eof_err_o,
    output logic  soc_o,
    output logic  sof_o,
    output logic  disp_rst_o,
    output logic  pol_inv_o,
    output logic  in_frame_o,
    output logic  frame_err_o,
    output logic  done_o
);

    seq_t q, d;
    logic ed_fits;
    logic sd_fits;
    logic done;

    assign ed_fits = q.in_frame ? (kind_i == K_EOF_OK || kind_i == K_EOF_ERR)
                                : (kind_i == K_EOC);
    assign sd_fits = (kind_i == K_SOC || kind_i == K_SOF) && (inv_i == q.ed_inv);

    always_comb begin
        d         = q;
        d.comma   = 1'b0;
        d.eoc     = 1'b0;
        d.eof_ok  = 1'b0;
        d.eof_err = 1'b0;
        d.soc     = 1'b0;
        d.sof     = 1'b0;
        d.drst    = 1'b0;
        d.ferr    = 1'b0;
        done      = 1'b0;
        if (valid_i) begin
            unique case (q.phase)
                PH_STREAM: begin
                    if (zero_i) d.phase = PH_ZERO1;
                end
                PH_ZERO1: begin
                    if (zero_i) begin
                        d.phase = PH_ENDD;
                        d.comma = 1'b1;
                    end else begin
                        d.phase = PH_STREAM;
                    end
                end
                PH_ENDD: begin
                    if (ed_fits) begin
                        d.ed_kind = kind_i;
                        d.ed_inv  = inv_i;
                        d.phase   = PH_STARTD;
                    end else begin
                        d.ferr     = 1'b1;
                        d.in_frame = 1'b0;
                        d.phase    = PH_STREAM;
                    end
                end
                PH_STARTD: begin
                    if (sd_fits) begin
                        done       = 1'b1;
                        d.eoc      = (q.ed_kind == K_EOC);
                        d.eof_ok   = (q.ed_kind == K_EOF_OK);
                        d.eof_err  = (q.ed_kind == K_EOF_ERR);
                        d.soc      = (kind_i == K_SOC);
                        d.sof      = (kind_i == K_SOF);
                        d.drst     = 1'b1;
                        d.pol      = inv_i;
                        d.in_frame = (kind_i == K_SOF);
                    end else begin
                        d.ferr     = 1'b1;
                        d.in_frame = 1'b0;
                    end
                    d.phase = PH_STREAM;
                end
                default: d.phase = PH_STREAM;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign comma_o     = q.comma;
    assign eoc_o       = q.eoc;
    assign eof_ok_o    = q.eof_ok;
    assign eof_err_o   = q.eof_err;
    assign soc_o       = q.soc;
    assign sof_o       = q.sof;
    assign disp_rst_o  = q.drst;
    assign pol_inv_o   = q.pol;
    assign in_frame_o  = q.in_frame;
    assign frame_err_o = q.ferr;
    assign done_o      = done;

    // R2
    end_kind_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({q.eoc, q.eof_ok, q.eof_err}));

    // R5
    sof_opens_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.sof |-> q.in_frame);

    // R6
    eof_from_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.eof_ok || q.eof_err) |-> $past(q.in_frame));

    // R6
    eoc_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.eoc |-> !$past(q.in_frame));

    // R3
    pol_moves_on_drst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.pol) |-> q.drst);

    // R10
    no_pulse_without_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valid_i) |-> !(q.comma || q.drst || q.ferr));

endmodule

// File: rtl/tsf_watchdog.sv
module tsf_watchdog #(
    parameter int IDLE_LIMIT = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    input  logic in_frame_i,
    input  logic done_i,
    output logic sync_lost_o
);

    localparam int CNT_W = $clog2(IDLE_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_LIMIT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             lost;
    } wd_t;

    wd_t q, d;

    always_comb begin
        d = q;
        if (valid_i) begin
            if (done_i) begin
                d.cnt  = '0;
                d.lost = 1'b0;
            end else if (!in_frame_i) begin
                if (q.cnt == CNT_LAST) d.lost = 1'b1;
                else                   d.cnt  = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_lost_o = q.lost;

    // R8
    lost_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.lost) |-> ($past(valid_i) && !$past(in_frame_i)));

    // R9
    lost_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.lost) |-> $past(done_i));

endmodule

// File: rtl/tsf_framer.sv
module tsf_framer
    import tsf_pkg::*;
#(
    parameter int IDLE_LIMIT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trip_valid_i,
    input  logic [TRIP_W-1:0] trip_i,
    output logic              comma_o,
    output logic              eoc_o,
    output logic              eof_ok_o,
    output logic              eof_err_o,
    output logic              soc_o,
    output logic              sof_o,
    output logic              disp_rst_o,
    output logic              pol_inv_o,
    output logic              in_frame_o,
    output logic              frame_err_o,
    output logic              sync_lost_o
);

    kind_e kind;
    logic  inv;
    logic  zero;
    logic  done;

    tsf_classify u_cls (
        .trip_i (trip_i),
        .kind_o (kind),
        .inv_o  (inv),
        .zero_o (zero)
    );

    tsf_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (trip_valid_i),
        .kind_i      (kind),
        .inv_i       (inv),
        .zero_i      (zero),
        .comma_o     (comma_o),
        .eoc_o       (eoc_o),
        .eof_ok_o    (eof_ok_o),
        .eof_err_o   (eof_err_o),
        .soc_o       (soc_o),
        .sof_o       (sof_o),
        .disp_rst_o  (disp_rst_o),
        .pol_inv_o   (pol_inv_o),
        .in_frame_o  (in_frame_o),
        .frame_err_o (frame_err_o),
        .done_o      (done)
    );

    tsf_watchdog #(.IDLE_LIMIT(IDLE_LIMIT)) u_wd (
        .clk         (clk),
        .rst_n       (rst_n),
        .valid_i     (trip_valid_i),
        .in_frame_i  (in_frame_o),
        .done_i      (done),
        .sync_lost_o (sync_lost_o)
    );

endmodule

// File: tb/tsf_framer_bench.sv
`timescale 1ns/1ps
module tsf_framer_bench;

    localparam int LIMIT = 256;
    localparam logic [1:0] Z = 2'b00;
    localparam logic [1:0] P = 2'b01;
    localparam logic [1:0] M = 2'b11;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       trip_valid;
    logic [5:0] trip;
    logic comma_o, eoc_o, eof_ok_o, eof_err_o, soc_o, sof_o;
    logic disp_rst_o, pol_inv_o, in_frame_o, frame_err_o, sync_lost_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    // reference model state
    int  m_phase = 0;
    bit  m_frame = 0, m_pol = 0, m_lost = 0, m_edinv = 0;
    int  m_cnt = 0, m_edk = 0;
    bit  e_comma, e_eoc, e_ok, e_err, e_soc, e_sof, e_drst, e_ferr;
    bit  prev_zero = 0;

    always #2.5 clk = ~clk;

    tsf_framer u_tsf_framer (
        .clk(clk), .rst_n(rst_n), .trip_valid_i(trip_valid), .trip_i(trip),
        .comma_o(comma_o), .eoc_o(eoc_o), .eof_ok_o(eof_ok_o), .eof_err_o(eof_err_o),
        .soc_o(soc_o), .sof_o(sof_o), .disp_rst_o(disp_rst_o), .pol_inv_o(pol_inv_o),
        .in_frame_o(in_frame_o), .frame_err_o(frame_err_o), .sync_lost_o(sync_lost_o)
    );

    function automatic logic [5:0] flip(input logic [5:0] t);
        logic [5:0] r;
        for (int i = 0; i < 3; i++) begin
            if (t[2*i +: 2] == P)      r[2*i +: 2] = M;
            else if (t[2*i +: 2] == M) r[2*i +: 2] = P;
            else                       r[2*i +: 2] = t[2*i +: 2];
        end
        return r;
    endfunction

    // 1 ctl end, 2 frame end good, 3 frame end bad, 4 ctl start, 5 frame start
    function automatic logic [5:0] code(input int k);
        case (k)
            1: return {P, Z, M};
            2: return {Z, P, M};
            3: return {P, M, Z};
            4: return {P, P, M};
            5: return {P, P, P};
            default: return {P, 2'b10, M};
        endcase
    endfunction

    function automatic int code_of(input logic [5:0] t, output bit inv);
        inv = 0;
        for (int k = 1; k <= 5; k++) begin
            if (t == code(k)) return k;
            if (t == flip(code(k))) begin inv = 1; return k; end
        end
        return 0;
    endfunction

    task automatic model_step(input bit v, input logic [5:0] t);
        int  k;
        bit  inv, zero, done, old_frame;
        {e_comma, e_eoc, e_ok, e_err, e_soc, e_sof, e_drst, e_ferr} = '0;
        if (!v) return;
        k = code_of(t, inv);
        zero = (t == 6'b0);
        done = 0;
        old_frame = m_frame;
        case (m_phase)
            0: if (zero) m_phase = 1;
            1: if (zero) begin m_phase = 2; e_comma = 1; end else m_phase = 0;
            2: if ((!m_frame && k == 1) || (m_frame && (k == 2 || k == 3))) begin
                   m_edk = k; m_edinv = inv; m_phase = 3;
               end else begin
                   e_ferr = 1; m_frame = 0; m_phase = 0;
               end
            default: begin
                if ((k == 4 || k == 5) && inv == m_edinv) begin
                    done = 1;
                    e_eoc = (m_edk == 1); e_ok = (m_edk == 2); e_err = (m_edk == 3);
                    e_soc = (k == 4); e_sof = (k == 5); e_drst = 1;
                    m_pol = inv; m_frame = (k == 5);
                end else begin
                    e_ferr = 1; m_frame = 0;
                end
                m_phase = 0;
            end
        endcase
        if (done) begin
            m_cnt = 0; m_lost = 0;
        end else if (!old_frame) begin
            if (m_cnt == LIMIT - 1) m_lost = 1;
            else m_cnt++;
        end
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [5:0] t);
        trip_valid = v;
        trip = t;
        model_step(v, t);
        if (v) prev_zero = (t == 6'b0);
        @(negedge clk);
        chk("R1 comma", 8'(comma_o), 8'(e_comma));
        chk("R2 markers", 8'({eoc_o, eof_ok_o, eof_err_o, soc_o, sof_o}),
            8'({e_eoc, e_ok, e_err, e_soc, e_sof}));
        chk("R4 disp_rst", 8'(disp_rst_o), 8'(e_drst));
        chk("R3 polarity", 8'(pol_inv_o), 8'(m_pol));
        chk("R5 in_frame", 8'(in_frame_o), 8'(m_frame));
        chk("R7 frame_err", 8'(frame_err_o), 8'(e_ferr));
        chk("R8 sync_lost", 8'(sync_lost_o), 8'(m_lost));
    endtask

    function automatic logic [1:0] rsym();
        int r;
        r = int'($urandom_range(0, 2));
        return (r == 0) ? Z : (r == 1) ? P : M;
    endfunction

    task automatic data(input int n);
        logic [5:0] t;
        for (int i = 0; i < n; i++) begin
            t = {rsym(), rsym(), rsym()};
            if (t == 6'b0 && (prev_zero || $urandom_range(0, 7) != 0)) t = {P, Z, M};
            step(1'b1, t);
        end
    endtask

    task automatic ctrl(input int ed, input int sd, input bit inv, input bit mism);
        step(1'b1, 6'b0);
        step(1'b1, 6'b0);
        step(1'b1, inv ? flip(code(ed)) : code(ed));
        step(1'b1, (inv ^ mism) ? flip(code(sd)) : code(sd));
    endtask

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0;
        trip_valid = 1'b0;
        trip = '0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset", 8'({comma_o, eoc_o, eof_ok_o, eof_err_o, soc_o, sof_o, disp_rst_o,
                             pol_inv_o}), 8'h00);
        chk("R11 reset", 8'({in_frame_o, frame_err_o, sync_lost_o}), 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 after reset", 8'({comma_o, disp_rst_o, in_frame_o, sync_lost_o}), 8'h00);

        // R1 R2: plain idle control sequence
        data(10);
        ctrl(1, 4, 0, 0);
        chk("R2 ctl end/start", 8'({eoc_o, soc_o}), 8'b11);
        // R1: lone zero triplet is data
        step(1'b1, 6'b0);
        step(1'b1, {P, M, P});
        chk("R1 lone zero", 8'(comma_o), 8'h00);
        // R5: open and close a frame
        ctrl(1, 5, 0, 0);
        chk("R5 frame open", 8'(in_frame_o), 8'h01);
        data(40);
        ctrl(2, 4, 0, 0);
        chk("R5 frame closed", 8'({eof_ok_o, in_frame_o}), 8'b10);
        // R3: negated polarity
        ctrl(1, 5, 1, 0);
        chk("R3 negated", 8'({pol_inv_o, sof_o}), 8'b11);
        data(12);
        ctrl(3, 4, 1, 0);
        chk("R2 bad frame end", 8'(eof_err_o), 8'h01);
        ctrl(1, 4, 0, 0);
        chk("R3 back to normal", 8'(pol_inv_o), 8'h00);
        // R6: wrong end marker for link state
        ctrl(2, 4, 0, 0);
        chk("R6 frame end in idle", 8'(in_frame_o), 8'h00);
        ctrl(1, 5, 0, 0);
        data(8);
        step(1'b1, 6'b0); step(1'b1, 6'b0); step(1'b1, code(1));
        chk("R6 ctl end in frame", 8'({frame_err_o, in_frame_o}), 8'b10);
        // R7: polarity mismatch, illegal start marker
        ctrl(1, 4, 0, 1);
        chk("R7 mismatch", 8'({frame_err_o, disp_rst_o}), 8'b10);
        ctrl(1, 0, 1, 0);
        chk("R7 illegal start", 8'(frame_err_o), 8'h01);
        // R10: comma split by idle cycles
        step(1'b1, 6'b0);
        step(1'b0, 6'b0);
        chk("R10 gap quiet", 8'({comma_o, frame_err_o, disp_rst_o}), 8'h00);
        step(1'b0, {P, P, P});
        step(1'b1, 6'b0);
        chk("R10 comma across gap", 8'(comma_o), 8'h01);
        step(1'b1, code(1));
        step(1'b1, code(4));
        // R8: exact limit
        data(LIMIT - 1);
        chk("R8 below limit", 8'(sync_lost_o), 8'h00);
        data(1);
        chk("R8 at limit", 8'(sync_lost_o), 8'h01);
        ctrl(1, 4, 0, 0);
        chk("R9 cleared", 8'(sync_lost_o), 8'h00);
        // R8: frame time not counted
        ctrl(1, 5, 0, 0);
        data(LIMIT + 50);
        chk("R8 frame not counted", 8'(sync_lost_o), 8'h00);
        ctrl(2, 4, 0, 0);

        // random mix
        for (int it = 0; it < 900; it++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            if (sel < 4) data(int'($urandom_range(1, 12)));
            else if (sel < 8) begin
                int ed, sd;
                ed = m_frame ? int'($urandom_range(2, 3)) : 1;
                if ($urandom_range(0, 5) == 0) ed = int'($urandom_range(0, 5));
                sd = int'($urandom_range(4, 5));
                if ($urandom_range(0, 7) == 0) sd = int'($urandom_range(0, 3));
                ctrl(ed, sd, 1'($urandom_range(0, 1)), ($urandom_range(0, 9) == 0));
            end else if (sel == 8) step(1'b0, 6'($urandom));
            else step(1'b1, 6'($urandom));
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule